// File: doc/BRIEF.md
# Peripheral Interrupt Register Block

This block gathers eight interrupt sources belonging to one peripheral and presents them to software through a small byte-wide register window. Each source can be set up to trigger on a level or on an edge. Each source also has two polarity bits. On an edge source the two bits can select both edges at once. On a level source they select whether the source is active high or active low. A detected event is latched per source. A separate enable mask decides which latched sources drive the single upward interrupt request.

Software reaches the block through a synchronous access port with an 8-bit offset into a 256-byte window. A beat marked as the first of a burst carries its own address. Each later beat of the same burst uses the next offset, so the three configuration registers can be filled in one burst. Enables are changed through separate set and clear registers, and latched events are cleared by writing ones. A mask-and-acknowledge sequence is therefore two plain writes: the enable-clear register first, then the latched-clear register.

Top module: `perirq_unit`

## Requirements
- R1: After reset every register is zero, `irq_out` is low, and a read of any offset from 0x00 to 0x1F returns 0x00.
- R2: Read data appears on `acc_rdata` one clock after the read beat and holds until the next read. The read map is: 0x10 live status, 0x11 trigger kind, 0x12 high polarity, 0x13 low polarity, 0x15 and 0x16 the enable mask, and 0x18 latched status. Offset 0x14 and every unmapped offset read 0x00. Bit n of every register belongs to source n.
- R3: A beat with `acc_start` low uses the offset of the previous beat plus one. A burst of three writes starting at 0x11 therefore loads the kind, high-polarity and low-polarity registers in that order.
- R4: When a source's kind bit is 1 (edge), a rising edge latches it if its high-polarity bit is 1, and a falling edge latches it if its low-polarity bit is 1. With both bits set, both edges latch.
- R5: Writing a mask to 0x15 sets the enable bits where the mask is one. Writing a mask to 0x16 clears them. Zero mask bits leave enables unchanged.
- R6: When a source's kind bit is 0 (level), the source latches on every cycle in which it is active: high when its high-polarity bit is 1, and low when only its low-polarity bit is 1. If it is still active after a clear, it latches again.
- R7: Writing a mask to 0x14 clears those latched bits. An event detected in the same cycle as the clear leaves its bit set.
- R8: Events latch whatever the enable bits are. `irq_out` is high exactly when some source is both latched and enabled.
- R9: Bit n at 0x10 is the synchronized input of source n, inverted when its low-polarity bit is 1 and its high-polarity bit is 0.
- R10: An input change that makes an event shows in the latched status on the third rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Raw interrupt source lines, may be asynchronous |
| acc_valid | input | 1 | Access beat present this cycle |
| acc_start | input | 1 | Beat is the first of a burst; take `acc_addr` |
| acc_write | input | 1 | 1 = write beat, 0 = read beat |
| acc_addr | input | AW | Offset in the peripheral window (first beat) |
| acc_wdata | input | NSRC | Write data / mask byte |
| acc_rdata | output | NSRC | Registered read data |
| irq_out | output | 1 | Summary interrupt request |

## Verification
The properties assume that access beats are whole cycles, with `acc_valid`, `acc_write`, the offset and the data stable around each clock edge. They also assume that a level source is never set up with both polarity bits at once. The stimulus keeps to this in three ways. It changes every input only on falling clock edges. It writes configuration only as three-byte bursts built from one of five legal trigger modes. It raises or lowers one source at a time, with the others held low and left with no polarity set.

// File: rtl/perirq_pkg.sv
package perirq_pkg;
   localparam int PI_WIDTH = 8;
   localparam int PI_WIN_W = 8;

   localparam logic [7:0] OFS_LIVE  = 8'h10;
   localparam logic [7:0] OFS_KIND  = 8'h11;
   localparam logic [7:0] OFS_POLHI = 8'h12;
   localparam logic [7:0] OFS_POLLO = 8'h13;
   localparam logic [7:0] OFS_ACK   = 8'h14;
   localparam logic [7:0] OFS_ENSET = 8'h15;
   localparam logic [7:0] OFS_ENCLR = 8'h16;
   localparam logic [7:0] OFS_PEND  = 8'h18;
endpackage

// File: rtl/perirq_port.sv
module perirq_port #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_valid,
   input  logic          acc_start,
   input  logic [AW-1:0] acc_addr,
   output logic [AW-1:0] beat_addr
);
   logic [AW-1:0] next_q;

   // first beat takes its own offset, continuation beats walk upward
   assign beat_addr = acc_start ? acc_addr : next_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         next_q <= '0;
      else if (acc_valid) next_q <= beat_addr + AW'(1);
   end
endmodule

// File: rtl/perirq_detect.sv
module perirq_detect #(
   parameter int NSRC        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_in,
   input  logic [NSRC-1:0] cfg_edge,
   input  logic [NSRC-1:0] cfg_hi,
   input  logic [NSRC-1:0] cfg_lo,
   output logic [NSRC-1:0] live,
   output logic [NSRC-1:0] hit
);
   localparam int TOP = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("perirq_detect: SYNC_STAGES must be at least 2");
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic [SYNC_STAGES-1:0] chain;
      logic                   prev_q;
      logic                   now_v;
      logic                   edge_hit;
      logic                   lvl_hit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain  <= '0;
            prev_q <= 1'b0;
         end else begin
            chain  <= {chain[TOP-1:0], src_in[i]};
            prev_q <= chain[TOP];
         end
      end

      assign now_v    = chain[TOP];
      assign edge_hit = (cfg_hi[i] & now_v & ~prev_q) | (cfg_lo[i] & ~now_v & prev_q);
      assign lvl_hit  = cfg_hi[i] ? now_v : (cfg_lo[i] & ~now_v);
      assign hit[i]   = cfg_edge[i] ? edge_hit : lvl_hit;
      assign live[i]  = now_v;
   end
endmodule

// File: rtl/perirq_regs.sv
module perirq_regs
   import perirq_pkg::*;
#(
   parameter int NSRC = 8,
   parameter int AW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            beat_valid,
   input  logic            beat_write,
   input  logic [AW-1:0]   beat_addr,
   input  logic [NSRC-1:0] beat_wdata,
   input  logic [NSRC-1:0] hit,
   input  logic [NSRC-1:0] live,
   output logic [NSRC-1:0] cfg_edge,
   output logic [NSRC-1:0] cfg_hi,
   output logic [NSRC-1:0] cfg_lo,
   output logic [NSRC-1:0] en_q,
   output logic [NSRC-1:0] pend_q,
   output logic [NSRC-1:0] rdata_q
);
   logic            wr_sel, rd_sel;
   logic [NSRC-1:0] ack_mask, set_mask, clr_mask;
   logic [NSRC-1:0] shown_live;
   logic [NSRC-1:0] rd_mux;

   assign wr_sel   = beat_valid & beat_write;
   assign rd_sel   = beat_valid & ~beat_write;
   assign ack_mask = (wr_sel && beat_addr == AW'(OFS_ACK))   ? beat_wdata : '0;
   assign set_mask = (wr_sel && beat_addr == AW'(OFS_ENSET)) ? beat_wdata : '0;
   assign clr_mask = (wr_sel && beat_addr == AW'(OFS_ENCLR)) ? beat_wdata : '0;

   // inverted view only for sources that watch the low side alone
   assign shown_live = live ^ (cfg_lo & ~cfg_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_edge <= '0;
         cfg_hi   <= '0;
         cfg_lo   <= '0;
      end else if (wr_sel) begin
         if (beat_addr == AW'(OFS_KIND))  cfg_edge <= beat_wdata;
         if (beat_addr == AW'(OFS_POLHI)) cfg_hi   <= beat_wdata;
         if (beat_addr == AW'(OFS_POLLO)) cfg_lo   <= beat_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pend_q <= '0;
      end else begin
         en_q   <= (en_q | set_mask) & ~clr_mask;
         pend_q <= (pend_q & ~ack_mask) | hit;   // new event outranks a clear
      end
   end

   always_comb begin
      rd_mux = '0;
      case (beat_addr)
         AW'(OFS_LIVE):  rd_mux = shown_live;
         AW'(OFS_KIND):  rd_mux = cfg_edge;
         AW'(OFS_POLHI): rd_mux = cfg_hi;
         AW'(OFS_POLLO): rd_mux = cfg_lo;
         AW'(OFS_ENSET): rd_mux = en_q;
         AW'(OFS_ENCLR): rd_mux = en_q;
         AW'(OFS_PEND):  rd_mux = pend_q;
         default:        rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_sel) rdata_q <= rd_mux;
   end
endmodule

// File: rtl/perirq_unit.sv
module perirq_unit
   import perirq_pkg::*;
#(
   parameter int NSRC        = 8,
   parameter int AW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_in,
   input  logic            acc_valid,
   input  logic            acc_start,
   input  logic            acc_write,
   input  logic [AW-1:0]   acc_addr,
   input  logic [NSRC-1:0] acc_wdata,
   output logic [NSRC-1:0] acc_rdata,
   output logic            irq_out
);
   if (NSRC != PI_WIDTH) begin : g_bad_width
      $error("perirq_unit: NSRC must equal the register byte width");
   end
   if (AW < PI_WIN_W) begin : g_bad_addr
      $error("perirq_unit: AW too narrow for the peripheral window");
   end

   logic [AW-1:0]   beat_addr;
   logic [NSRC-1:0] cfg_edge, cfg_hi, cfg_lo;
   logic [NSRC-1:0] live, hit, en_q, pend_q;

   perirq_port #(.AW(AW)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_start (acc_start),
      .acc_addr  (acc_addr),
      .beat_addr (beat_addr)
   );

   perirq_detect #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_in   (src_in),
      .cfg_edge (cfg_edge),
      .cfg_hi   (cfg_hi),
      .cfg_lo   (cfg_lo),
      .live     (live),
      .hit      (hit)
   );

   perirq_regs #(.NSRC(NSRC), .AW(AW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_valid (acc_valid),
      .beat_write (acc_write),
      .beat_addr  (beat_addr),
      .beat_wdata (acc_wdata),
      .hit        (hit),
      .live       (live),
      .cfg_edge   (cfg_edge),
      .cfg_hi     (cfg_hi),
      .cfg_lo     (cfg_lo),
      .en_q       (en_q),
      .pend_q     (pend_q),
      .rdata_q    (acc_rdata)
   );

   assign irq_out = |(pend_q & en_q);
endmodule

// File: rtl/perirq_unit_chk.sv
module perirq_unit_chk
   import perirq_pkg::*;
#(
   parameter int NSRC = 8,
   parameter int AW   = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            beat_valid,
   input logic            beat_write,
   input logic [AW-1:0]   beat_addr,
   input logic [NSRC-1:0] beat_wdata,
   input logic [NSRC-1:0] hit,
   input logic [NSRC-1:0] en_q,
   input logic [NSRC-1:0] pend_q,
   input logic [NSRC-1:0] rdata,
   input logic            irq_out
);
   logic wr_set, wr_clr, wr_ack, rd_unused;

   assign wr_set    = beat_valid & beat_write & (beat_addr == AW'(OFS_ENSET));
   assign wr_clr    = beat_valid & beat_write & (beat_addr == AW'(OFS_ENCLR));
   assign wr_ack    = beat_valid & beat_write & (beat_addr == AW'(OFS_ACK));
   assign rd_unused = beat_valid & ~beat_write &
                      !(beat_addr inside {AW'(OFS_LIVE), AW'(OFS_KIND), AW'(OFS_POLHI),
                                          AW'(OFS_POLLO), AW'(OFS_ENSET), AW'(OFS_ENCLR),
                                          AW'(OFS_PEND)});

   p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((en_q & $past(beat_wdata)) == $past(beat_wdata)));

   p_en_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((en_q & $past(beat_wdata)) == '0));

   p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ack |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

   p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((pend_q & $past(hit)) == $past(hit)));

   p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq_out);

   p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_unused |=> (rdata == '0));
endmodule

bind perirq_unit perirq_unit_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .beat_valid (acc_valid),
   .beat_write (acc_write),
   .beat_addr  (beat_addr),
   .beat_wdata (acc_wdata),
   .hit        (hit),
   .en_q       (en_q),
   .pend_q     (pend_q),
   .rdata      (acc_rdata),
   .irq_out    (irq_out)
);

// File: tb/perirq_unit_test.sv
module perirq_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] src_in = '0;
   logic       acc_valid = 1'b0, acc_start = 1'b0, acc_write = 1'b0;
   logic [7:0] acc_addr = '0, acc_wdata = '0;
   logic [7:0] acc_rdata;
   logic       irq_out;
   int         nchk = 0, nfail = 0;

   always #4 clk = ~clk;

   perirq_unit uut (
      .clk(clk), .rst_n(rst_n), .src_in(src_in),
      .acc_valid(acc_valid), .acc_start(acc_start), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic beat(input logic st, input logic wr, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_start = st; acc_write = wr; acc_addr = a; acc_wdata = d;
      @(posedge clk);
   endtask

   task automatic idle();
      @(negedge clk);
      acc_valid = 1'b0; acc_start = 1'b0; acc_write = 1'b0;
   endtask

   task automatic wr1(input logic [7:0] a, input logic [7:0] d);
      beat(1'b1, 1'b1, a, d);
      idle();
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      beat(1'b1, 1'b0, a, 8'h00);
      idle();
      v = acc_rdata;
   endtask

   task automatic cfg3(input logic [7:0] k, input logic [7:0] h, input logic [7:0] l);
      beat(1'b1, 1'b1, 8'h11, k);
      beat(1'b0, 1'b1, 8'h00, h);
      beat(1'b0, 1'b1, 8'h00, l);
      idle();
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);

      // R1: reset state over a sweep of the low window
      chk("R1 irq after reset", {7'b0, irq_out}, 8'h00);
      for (int a = 0; a < 32; a++) begin
         rd(8'(a), v);
         chk($sformatf("R1 reset read %02h", a), v, 8'h00);
      end

      // R3 / R2: burst fills three configuration registers
      beat(1'b1, 1'b1, 8'h11, 8'hA5);
      beat(1'b0, 1'b1, 8'h00, 8'h3C);
      beat(1'b0, 1'b1, 8'h00, 8'h81);
      idle();
      rd(8'h11, v); chk("R3 burst kind", v, 8'hA5);
      rd(8'h12, v); chk("R3 burst polhi", v, 8'h3C);
      rd(8'h13, v); chk("R3 burst pollo", v, 8'h81);
      cfg3(8'h00, 8'h00, 8'h00);

      // R5: set and clear enables, zero mask bits untouched
      wr1(8'h15, 8'h0F); rd(8'h15, v); chk("R5 set", v, 8'h0F);
      wr1(8'h15, 8'h30); rd(8'h15, v); chk("R5 set keeps", v, 8'h3F);
      wr1(8'h16, 8'h05); rd(8'h16, v); chk("R5 clear", v, 8'h3A);
      rd(8'h14, v); chk("R2 ack reads zero", v, 8'h00);
      rd(8'h17, v); chk("R2 hole reads zero", v, 8'h00);
      rd(8'h19, v); chk("R2 above map zero", v, 8'h00);
      wr1(8'h16, 8'hFF);
      wr1(8'h15, 8'hAA);

      // R4 R6 R8 R9: every source under every trigger mode
      for (int n = 0; n < 8; n++) begin
         for (int m = 0; m < 5; m++) begin
            logic [7:0] bit_n, pend, kind, hi, lo, inv;
            bit_n = 8'(1 << n);
            kind  = (m < 3) ? bit_n : 8'h00;
            hi    = (m == 0 || m == 2 || m == 3) ? bit_n : 8'h00;
            lo    = (m == 1 || m == 2 || m == 4) ? bit_n : 8'h00;
            inv   = lo & ~hi;
            cfg3(kind, hi, lo);
            cyc(2);
            wr1(8'h14, 8'hFF);
            pend = (m == 4) ? bit_n : 8'h00;
            rd(8'h18, v); chk($sformatf("R6 idle s%0d m%0d", n, m), v, pend);
            rd(8'h10, v); chk($sformatf("R9 live low s%0d m%0d", n, m), v, inv);
            chk($sformatf("R8 irq idle s%0d m%0d", n, m), {7'b0, irq_out}, {7'b0, |(pend & 8'hAA)});

            @(negedge clk); src_in = bit_n; cyc(4);
            pend = pend | hi;
            rd(8'h18, v); chk($sformatf("R4 rise s%0d m%0d", n, m), v, pend);
            rd(8'h10, v); chk($sformatf("R9 live high s%0d m%0d", n, m), v, bit_n ^ inv);
            chk($sformatf("R8 irq rise s%0d m%0d", n, m), {7'b0, irq_out}, {7'b0, |(pend & 8'hAA)});

            wr1(8'h14, 8'hFF);
            pend = (m == 3) ? bit_n : 8'h00;
            rd(8'h18, v); chk($sformatf("R6 relatch s%0d m%0d", n, m), v, pend);

            @(negedge clk); src_in = 8'h00; cyc(4);
            pend = pend | lo;
            rd(8'h18, v); chk($sformatf("R4 fall s%0d m%0d", n, m), v, pend);
            chk($sformatf("R8 irq fall s%0d m%0d", n, m), {7'b0, irq_out}, {7'b0, |(pend & 8'hAA)});
         end
      end

      // R10: three-edge latency, seen through irq_out
      cfg3(8'h04, 8'h04, 8'h00);
      wr1(8'h16, 8'hFF);
      wr1(8'h15, 8'h04);
      wr1(8'h14, 8'hFF);
      @(negedge clk); src_in = 8'h04;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R10 not yet after two edges", {7'b0, irq_out}, 8'h00);
      @(posedge clk); @(negedge clk);
      chk("R10 latched on third edge", {7'b0, irq_out}, 8'h01);

      // R7: clear and new event in the same cycle
      @(negedge clk); src_in = 8'h00; cyc(4);
      @(negedge clk); src_in = 8'h04;
      @(posedge clk); @(posedge clk);
      beat(1'b1, 1'b1, 8'h14, 8'hFF);
      idle();
      rd(8'h18, v); chk("R7 event survives clear", v, 8'h04);
      wr1(8'h14, 8'h04);
      rd(8'h18, v); chk("R7 clear without event", v, 8'h00);
      chk("R8 irq after clear", {7'b0, irq_out}, 8'h00);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule